// File: doc/BRIEF.md
# Serial Codec Configuration Sequencer

This block sets up an audio codec after reset, without a processor. It runs on the fast system clock and derives a slow two-wire serial bus from it, a clock line and a data line in the I2C style. It walks a fixed list of configuration words once. Every 24-bit word is sent as its own bus transaction. A transaction opens with a start condition and then carries three bytes, most significant bit first. Each byte is followed by one bit slot in which the block releases the data line so the codec can acknowledge. A stop condition closes the transaction.

One frame takes 29 bit slots, and each slot lasts `BIT_CLKS` system clocks. The default is 500, which gives 100 kHz from 50 MHz. The next frame starts directly after the stop slot. When the final stop condition is complete, `done` rises and both bus lines are parked high. The block then stays in that state until the next synchronous, active-low reset. It never reads the acknowledge back. Word `i` of the list is made of three parts, in this order: the device byte `DEV_ADDR`, then `i` in 7 bits, then `(37*i + 5) mod 512` in 9 bits.

Top module: `codec_cfg_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to the first clock of word 0's start slot. After that edge `scl_o`=1, `sda_o`=1, `sda_oe`=1 and `done`=0.
- R2: Every bit slot lasts exactly `BIT_CLKS` clocks, and every frame has 29 slots in this order: start, then three times (8 data bits followed by an acknowledge slot), then stop.
- R3: In a data slot with quarter length Q=`BIT_CLKS`/4, `scl_o` is low for phases [0,Q), high for [Q,3Q) and low for [3Q,`BIT_CLKS`). `sda_o` changes only at phase 0.
- R4: In the start slot, `scl_o` is high for phases [0,3Q) and low afterwards. `sda_o` is 1 for [0,2Q) and 0 afterwards, so the data line falls while the clock is high.
- R5: In the stop slot, `scl_o` is low for [0,Q) and high afterwards. `sda_o` is 0 for [0,2Q) and 1 afterwards, so the data line rises while the clock is high.
- R6: `sda_oe` is 0 for the whole of each acknowledge slot (slots 9, 18 and 27) and 1 at all other times.
- R7: The 11 words are sent in index order, with word `i` = {`DEV_ADDR`, i[6:0], (37*i+5)[8:0]}. Each byte goes out most significant bit first.
- R8: `done` rises on the first clock after the last stop slot. From then on `scl_o`=1, `sda_o`=1 and `sda_oe`=1, and nothing changes until reset.
- R9: The start slot of word i+1 follows the stop slot of word i with no idle clocks between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_o | output | 1 | Serial bus clock |
| sda_o | output | 1 | Data value driven onto the data line |
| sda_oe | output | 1 | Data line drive enable, 0 = high impedance |
| done | output | 1 | Whole configuration list has been sent |

## Verification
The main pattern is a full run of all 11 words. Every clock is compared against a bus model built from slot index and phase. This model exposes slot timing errors, edge placement errors inside the start, stop and data slots, and bit order errors in the words. The word values differ in every field, so a word counter that skips an entry or repeats one shows up as wrong data bits. A reset once the list is finished, and a second reset in the middle of the first word, separate a true restart from one that keeps the word or phase counters. Sampling well past the end shows whether the idle state holds.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [1:0] {
    SLOT_START = 2'd0,
    SLOT_DATA  = 2'd1,
    SLOT_ACK   = 2'd2,
    SLOT_STOP  = 2'd3
  } slot_kind_e;

  localparam int FRAME_SLOTS = 29;
  localparam int WORD_BITS   = 24;
  localparam int SLOT_W      = 5;

  // Slot 0 opens the frame, slot 28 closes it, and an acknowledge follows every 8 data slots.
  function automatic slot_kind_e kind_of(input logic [SLOT_W-1:0] slot);
    if (slot == 5'd0)                                 return SLOT_START;
    else if (slot == 5'(FRAME_SLOTS - 1))             return SLOT_STOP;
    else if (slot == 5'd9 || slot == 5'd18 || slot == 5'd27) return SLOT_ACK;
    else                                              return SLOT_DATA;
  endfunction

  // Configuration word for a given list index.
  function automatic logic [WORD_BITS-1:0] cfg_word(input logic [7:0] dev,
                                                    input logic [6:0] idx);
    logic [15:0] val;
    val = 16'(idx) * 16'd37 + 16'd5;
    return {dev, idx, val[8:0]};
  endfunction

endpackage

// File: rtl/cfg_bit_timer.sv
module cfg_bit_timer #(
  parameter int BIT_CLKS = 500,
  localparam int PW = $clog2(BIT_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [PW-1:0] phase,
  output logic          bit_end
);
  localparam logic [PW-1:0] LAST_PH = PW'(BIT_CLKS - 1);

  assign bit_end = run && (phase == LAST_PH);

  always_ff @(posedge clk) begin
    if (!rst_n)        phase <= '0;
    else if (bit_end)  phase <= '0;
    else if (run)      phase <= phase + 1'b1;
  end
endmodule

// File: rtl/cfg_frame_seq.sv
module cfg_frame_seq
  import cfg_seq_pkg::*;
#(
  parameter int          WORDS    = 11,
  parameter logic [7:0]  DEV_ADDR = 8'h34,
  localparam int WW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_end,
  output slot_kind_e kind,
  output logic       data_bit,
  output logic       done
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);
  localparam logic [WW-1:0]     LAST_WORD = WW'(WORDS - 1);

  logic [SLOT_W-1:0]    bit_left;
  logic [SLOT_W-1:0]    slot;
  logic [WW-1:0]        word_idx;
  logic [WORD_BITS-1:0] shreg;

  assign slot     = LAST_SLOT - bit_left;
  assign kind     = kind_of(slot);
  assign data_bit = shreg[WORD_BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_left <= LAST_SLOT;
      word_idx <= '0;
      shreg    <= cfg_word(DEV_ADDR, 7'd0);
      done     <= 1'b0;
    end else if (bit_end) begin
      if (bit_left == '0) begin
        bit_left <= LAST_SLOT;
        if (word_idx == LAST_WORD) begin
          done <= 1'b1;
        end else begin
          word_idx <= word_idx + 1'b1;
          shreg    <= cfg_word(DEV_ADDR, 7'(word_idx + 1'b1));
        end
      end else begin
        bit_left <= bit_left - 1'b1;
        if (kind == SLOT_DATA) shreg <= {shreg[WORD_BITS-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/cfg_line_drv.sv
module cfg_line_drv
  import cfg_seq_pkg::*;
#(
  parameter int BIT_CLKS = 500,
  localparam int PW = $clog2(BIT_CLKS)
) (
  input  logic [PW-1:0] phase,
  input  slot_kind_e    kind,
  input  logic          data_bit,
  input  logic          done,
  output logic          scl_o,
  output logic          sda_o,
  output logic          sda_oe
);
  localparam logic [PW-1:0] Q1 = PW'(BIT_CLKS / 4);
  localparam logic [PW-1:0] Q2 = PW'(BIT_CLKS / 2);
  localparam logic [PW-1:0] Q3 = PW'(3 * (BIT_CLKS / 4));

  logic mid_half, late_half;
  assign mid_half  = (phase >= Q1) && (phase < Q3);
  assign late_half = (phase >= Q2);

  always_comb begin
    scl_o  = 1'b1;
    sda_o  = 1'b1;
    sda_oe = 1'b1;
    if (!done) begin
      unique case (kind)
        SLOT_START: begin
          scl_o = (phase < Q3);
          sda_o = !late_half;
        end
        SLOT_STOP: begin
          scl_o = (phase >= Q1);
          sda_o = late_half;
        end
        SLOT_ACK: begin
          scl_o  = mid_half;
          sda_oe = 1'b0;
        end
        default: begin
          scl_o = mid_half;
          sda_o = data_bit;
        end
      endcase
    end
  end
endmodule

// File: rtl/codec_cfg_seq.sv
module codec_cfg_seq
  import cfg_seq_pkg::*;
#(
  parameter int         BIT_CLKS = 500,
  parameter int         WORDS    = 11,
  parameter logic [7:0] DEV_ADDR = 8'h34
) (
  input  logic clk,
  input  logic rst_n,
  output logic scl_o,
  output logic sda_o,
  output logic sda_oe,
  output logic done
);
  localparam int PW = $clog2(BIT_CLKS);

  logic [PW-1:0] phase;
  logic          bit_end;
  slot_kind_e    kind;
  logic          data_bit;

  cfg_bit_timer #(.BIT_CLKS(BIT_CLKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (!done),
    .phase   (phase),
    .bit_end (bit_end)
  );

  cfg_frame_seq #(.WORDS(WORDS), .DEV_ADDR(DEV_ADDR)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_end  (bit_end),
    .kind     (kind),
    .data_bit (data_bit),
    .done     (done)
  );

  cfg_line_drv #(.BIT_CLKS(BIT_CLKS)) u_drv (
    .phase    (phase),
    .kind     (kind),
    .data_bit (data_bit),
    .done     (done),
    .scl_o    (scl_o),
    .sda_o    (sda_o),
    .sda_oe   (sda_oe)
  );
endmodule

// File: rtl/codec_cfg_seq_chk.sv
module codec_cfg_seq_chk
  import cfg_seq_pkg::*;
#(
  parameter int BIT_CLKS = 500,
  localparam int PW = $clog2(BIT_CLKS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_o,
  input logic          sda_o,
  input logic          sda_oe,
  input logic          done,
  input logic [PW-1:0] phase,
  input slot_kind_e    kind
);
  localparam logic [PW-1:0] Q1 = PW'(BIT_CLKS / 4);

  // R6
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == SLOT_ACK && !done) |-> !sda_oe);

  // R6
  drive_elsewhere_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != SLOT_ACK || done) |-> sda_oe);

  // R3
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && kind == SLOT_DATA && phase != '0) |-> $stable(sda_o));

  // R3
  scl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_o) && !done && kind != SLOT_START) |-> (phase == Q1));

  // R4
  start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_o) && scl_o && $past(scl_o) && sda_oe) |-> (kind == SLOT_START));

  // R5
  stop_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_o) && scl_o && $past(scl_o) && sda_oe && $past(sda_oe))
      |-> (kind == SLOT_STOP));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (scl_o && sda_o && sda_oe));
endmodule

bind codec_cfg_seq codec_cfg_seq_chk #(.BIT_CLKS(BIT_CLKS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .scl_o  (scl_o),
  .sda_o  (sda_o),
  .sda_oe (sda_oe),
  .done   (done),
  .phase  (phase),
  .kind   (kind)
);

// File: tb/codec_cfg_seq_tb.sv
`timescale 1ns/1ps
module codec_cfg_seq_tb;
  localparam int BC    = 8;
  localparam int QQ    = BC / 4;
  localparam int NW    = 11;
  localparam int SLOTS = 29;
  localparam int TOTAL = NW * SLOTS * BC;

  // R7: expected list, written from the word formula
  localparam logic [23:0] EXP_WORDS [NW] = '{
    24'h340005, 24'h34022A, 24'h34044F, 24'h340674, 24'h340899, 24'h340ABE,
    24'h340CE3, 24'h340F08, 24'h34112D, 24'h341352, 24'h341577
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_o, sda_o, sda_oe, done;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  codec_cfg_seq #(.BIT_CLKS(BC), .WORDS(NW), .DEV_ADDR(8'h34)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_o(scl_o), .sda_o(sda_o),
    .sda_oe(sda_oe), .done(done)
  );

  // Expected {done, scl, sda, oe} at clock c after reset release.
  // R2: slot = c / BC; R9: frames follow back to back, so word = slot / 29.
  function automatic logic [3:0] exp_bus(input int c, output string req);
    int b, ph, w, s, k, bp;
    logic e_scl, e_sda, e_oe;
    if (c >= TOTAL) begin
      req = "R8";
      return 4'b1111;
    end
    b = c / BC; ph = c % BC; w = b / SLOTS; s = b % SLOTS;
    e_oe = 1'b1; e_sda = 1'b1;
    e_scl = (ph >= QQ) && (ph < 3 * QQ);
    if (s == 0) begin
      req = "R4"; e_scl = (ph < 3 * QQ); e_sda = (ph < 2 * QQ);
    end else if (s == SLOTS - 1) begin
      req = "R5"; e_scl = (ph >= QQ); e_sda = (ph >= 2 * QQ);
    end else if (s == 9 || s == 18 || s == 27) begin
      req = "R6"; e_oe = 1'b0;
    end else begin
      req = "R3/R7";
      k = (s - 1) / 9; bp = (s - 1) % 9;
      e_sda = EXP_WORDS[w][23 - (k * 8 + bp)];
    end
    return {1'b0, e_scl, e_sda, e_oe};
  endfunction

  task automatic check_bus(input int c);
    string req;
    logic [3:0] e, a, m;
    e = exp_bus(c, req);
    a = {done, scl_o, sda_o, sda_oe};
    m = e[0] ? 4'b1111 : 4'b1101;
    checks++;
    if ((a & m) != (e & m)) begin
      errors++;
      $display("FAIL %s clock %0d: done/scl/sda/oe actual=%b expected=%b", req, c, a, e);
    end
  endtask

  task automatic check_reset_state(input string tag);
    checks++;
    if ({done, scl_o, sda_o, sda_oe} != 4'b0111) begin
      errors++;
      $display("FAIL R1 %s: done/scl/sda/oe actual=%b expected=0111", tag,
               {done, scl_o, sda_o, sda_oe});
    end
  endtask

  // Called at a falling edge with rst_n just released; checks n clocks.
  task automatic run_from_reset(input int n);
    for (int c = 0; c < n; c++) begin
      #1 check_bus(c);
      @(negedge clk);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    #1 check_reset_state("initial");
    // Full list, then idle (R2..R9)
    @(negedge clk);
    rst_n = 1'b1;
    run_from_reset(TOTAL + 40);
    // R1: reset after done restarts the list at word 0
    rst_n = 1'b0;
    @(negedge clk);
    #1 check_reset_state("after done");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run_from_reset(50);
    // R1: reset in the middle of word 0, then run into word 1 (R9)
    rst_n = 1'b0;
    @(negedge clk);
    #1 check_reset_state("mid frame");
    @(negedge clk);
    rst_n = 1'b1;
    run_from_reset(SLOTS * BC + 60);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(64'd200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule